// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block controls sixteen general-purpose pins, arranged as two banks of eight, through a byte-wide register bus with an 8-bit address, separate write and read strobes and combinational read data. Each pin owns two configuration bytes. One sets how the pad is driven: the output level, whether the pin drives, push-pull or open-drain, and the pull setting. The other picks which input edges raise an interrupt and returns the current pad level.

Pad inputs are brought into the clock domain through a two-flop synchronizer. A third flop holds the previous sample, and the block compares each new sample with it to find edges. A selected edge latches a sticky pending bit in its bank's status byte. Software acknowledges by writing ones back to that byte. The single interrupt line is the OR of pending bits that are not masked. Each bank has two mask bytes, one for normal operation and one for the low-power state, and the `low_power` input chooses between them.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset every output-control and input-control register reads 0x00, every pending bit is 0, all four mask bytes read 0xFF, all pin outputs are 0 and `irq` is 0.
- R2: The output-control byte of pin p is at 0x2B+p for p<8 and 0x3B+(p-8) for p>=8. It reads back as written. Bit 5 drives `pin_oe`, bit 4 drives `pin_od` (1 = open-drain), bit 3 drives `pin_pull_en`, bits 2:1 drive `pin_pull_sel[2p+1:2p]` (00 strong down, 01 strong up, 10 weak down, 11 weak up), and bit 0 drives `pin_out`. These outputs change only on a write to that byte.
- R3: The input-control byte of pin p is at 0x33+p for p<8 and 0x43+(p-8) for p>=8. Bits 2:1 are a writable edge select. Bit 0 reads the synchronized pad level, which follows a pad change after two clock edges. Bits 7:3 read 0. A write to bit 0 is ignored.
- R4: Edge select 00 sets no pending bit, 01 sets it on a falling edge, 10 on a rising edge and 11 on either. The bit is set on the third rising clock edge after the pad changes.
- R5: Pending bytes are at 0x0B (pins 0-7) and 0x0C (pins 8-15), with pin p at bit p mod 8. Writing 1 to a bit clears it and writing 0 leaves it alone. An edge that lands in the same cycle as its clear leaves the bit set.
- R6: Normal-state masks are at 0x19 (bank 0) and 0x1A (bank 1), and low-power masks are at 0x1B and 0x1C, with bit p mod 8 for pin p. A 1 masks the pin. `low_power`=0 selects the normal masks and 1 selects the low-power masks.
- R7: `irq` is 1 exactly when some pin has its pending bit set and its selected mask bit clear.
- R8: When `bus_rd` is 0, `bus_rdata` is 0x00. Reads of unmapped addresses return 0x00, and writes to them change no register.
- R9: A pending bit stays set until software clears it. Reading it does not clear it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, takes effect at the clock edge |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, combinational from address while `bus_rd` is 1 |
| pad_in | input | 16 | Asynchronous pad input levels |
| low_power | input | 1 | Selects the low-power mask set |
| irq | output | 1 | Interrupt to the host |
| pin_out | output | 16 | Output level per pin |
| pin_oe | output | 16 | Output enable per pin |
| pin_od | output | 16 | Open-drain select per pin |
| pin_pull_en | output | 16 | Pull enable per pin |
| pin_pull_sel | output | 32 | Pull select, two bits per pin |

## Verification
The assertions check on every cycle that pending bits are sticky when no write occurs, that a new pending bit appears only on a pin whose edge select was nonzero, that `irq` stays low with nothing pending or with every normal mask set, that read data is zero when no read is active, and that the drive enables hold without writes. Only the bench scenarios can show the exact latency from a pad change to the pending bit, the edge-type decoding, write-one-to-clear with set winning over clear, and the switch between mask sets under `low_power`. They also show the address map as a whole, including unmapped reads and writes.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int BANK_PINS_DEF = 8;
  localparam int NUM_BANKS_DEF = 2;
  localparam int BANK_STRIDE   = 16;

  localparam logic [7:0] ADDR_PEND0 = 8'h0B;
  localparam logic [7:0] ADDR_MRUN0 = 8'h19;
  localparam logic [7:0] ADDR_MLP0  = 8'h1B;
  localparam logic [7:0] ADDR_OCTL0 = 8'h2B;
  localparam logic [7:0] ADDR_ICTL0 = 8'h33;

  // output-control bit positions
  localparam int OC_DIR   = 5;
  localparam int OC_OD    = 4;
  localparam int OC_PEN   = 3;
  localparam int OC_PSEL  = 1;
  localparam int OC_LEVEL = 0;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_RISE = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  function automatic logic [7:0] octl_addr(int b, int p);
    return ADDR_OCTL0 + 8'(b * BANK_STRIDE + p);
  endfunction

  function automatic logic [7:0] ictl_addr(int b, int p);
    return ADDR_ICTL0 + 8'(b * BANK_STRIDE + p);
  endfunction
endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pad,
  output logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      prev_q <= '0;
    end else begin
      stage_q[0] <= pad;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      prev_q <= stage_q[STAGES-1];
    end
  end

  assign level = stage_q[STAGES-1];
  assign rise  = level & ~prev_q;
  assign fall  = ~level & prev_q;
endmodule

// File: rtl/gpio_pin_cfg.sv
module gpio_pin_cfg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_octl,
  input  logic       wr_ictl,
  input  logic [7:0] wdata,
  output logic [7:0] octl,
  output logic [1:0] esel
);
  import gpio_bank_pkg::*;

  logic [7:0] octl_q;
  logic [1:0] esel_q;
  logic [1:0] esel_d;

  always_comb esel_d = wdata[2:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      octl_q <= '0;
      esel_q <= EDGE_NONE;
    end else begin
      if (wr_octl) octl_q <= wdata;
      if (wr_ictl) esel_q <= esel_d;
    end
  end

  assign octl = octl_q;
  assign esel = esel_q;
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int BANK_PINS = 8,
  parameter int NUM_BANKS = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [BANK_PINS*NUM_BANKS-1:0] hit,
  input  logic [NUM_BANKS-1:0]           wr_pend,
  input  logic [NUM_BANKS-1:0]           wr_mrun,
  input  logic [NUM_BANKS-1:0]           wr_mlp,
  input  logic [BANK_PINS-1:0]           wdata,
  input  logic                           low_power,
  output logic [BANK_PINS*NUM_BANKS-1:0] pending,
  output logic [BANK_PINS*NUM_BANKS-1:0] mask_run,
  output logic [BANK_PINS*NUM_BANKS-1:0] mask_lp,
  output logic                           irq
);
  localparam int NUM_PINS = BANK_PINS * NUM_BANKS;

  logic [NUM_PINS-1:0] pend_q, pend_d;
  logic [NUM_PINS-1:0] mrun_q, mrun_d;
  logic [NUM_PINS-1:0] mlp_q, mlp_d;
  logic                pend_en, mask_en;

  always_comb begin
    pend_d = pend_q;
    mrun_d = mrun_q;
    mlp_d  = mlp_q;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (wr_pend[b]) pend_d[b*BANK_PINS +: BANK_PINS] = pend_q[b*BANK_PINS +: BANK_PINS] & ~wdata;
      if (wr_mrun[b]) mrun_d[b*BANK_PINS +: BANK_PINS] = wdata;
      if (wr_mlp[b])  mlp_d[b*BANK_PINS +: BANK_PINS]  = wdata;
    end
    pend_d  = pend_d | hit;
    pend_en = (|hit) | (|wr_pend);
    mask_en = (|wr_mrun) | (|wr_mlp);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mrun_q <= '1;
      mlp_q  <= '1;
    end else begin
      if (pend_en) pend_q <= pend_d;
      if (mask_en) begin
        mrun_q <= mrun_d;
        mlp_q  <= mlp_d;
      end
    end
  end

  assign pending  = pend_q;
  assign mask_run = mrun_q;
  assign mask_lp  = mlp_q;
  assign irq      = |(pend_q & ~(low_power ? mlp_q : mrun_q));
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank #(
  parameter int BANK_PINS   = gpio_bank_pkg::BANK_PINS_DEF,
  parameter int NUM_BANKS   = gpio_bank_pkg::NUM_BANKS_DEF,
  parameter int SYNC_STAGES = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [7:0]                           bus_addr,
  input  logic [7:0]                           bus_wdata,
  input  logic                                 bus_wr,
  input  logic                                 bus_rd,
  output logic [7:0]                           bus_rdata,
  input  logic [BANK_PINS*NUM_BANKS-1:0]       pad_in,
  input  logic                                 low_power,
  output logic                                 irq,
  output logic [BANK_PINS*NUM_BANKS-1:0]       pin_out,
  output logic [BANK_PINS*NUM_BANKS-1:0]       pin_oe,
  output logic [BANK_PINS*NUM_BANKS-1:0]       pin_od,
  output logic [BANK_PINS*NUM_BANKS-1:0]       pin_pull_en,
  output logic [2*BANK_PINS*NUM_BANKS-1:0]     pin_pull_sel
);
  import gpio_bank_pkg::*;

  localparam int NUM_PINS = BANK_PINS * NUM_BANKS;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sn = rst_pipe_q[1];

  logic [NUM_PINS-1:0]   lvl, rise, fall, hit;
  logic [NUM_PINS-1:0]   wr_o, wr_i;
  logic [NUM_PINS-1:0]   pend_q, mrun_q, mlp_q;
  logic [2*NUM_PINS-1:0] esel_flat;
  logic [7:0]            octl [NUM_PINS];
  logic [NUM_BANKS-1:0]  wr_pend, wr_mrun, wr_mlp;
  logic [7:0]            rdata_d;

  gpio_edge_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sn), .pad(pad_in),
    .level(lvl), .rise(rise), .fall(fall)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign wr_pend[b] = bus_wr && (bus_addr == ADDR_PEND0 + 8'(b));
    assign wr_mrun[b] = bus_wr && (bus_addr == ADDR_MRUN0 + 8'(b));
    assign wr_mlp[b]  = bus_wr && (bus_addr == ADDR_MLP0  + 8'(b));
    for (genvar p = 0; p < BANK_PINS; p++) begin : g_pin
      localparam int IDX = b * BANK_PINS + p;
      logic [1:0] esel;
      assign wr_o[IDX] = bus_wr && (bus_addr == octl_addr(b, p));
      assign wr_i[IDX] = bus_wr && (bus_addr == ictl_addr(b, p));
      gpio_pin_cfg u_cfg (
        .clk(clk), .rst_n(rst_sn), .wr_octl(wr_o[IDX]), .wr_ictl(wr_i[IDX]),
        .wdata(bus_wdata), .octl(octl[IDX]), .esel(esel)
      );
      assign esel_flat[2*IDX +: 2]    = esel;
      assign hit[IDX] = (esel_flat[2*IDX] & fall[IDX]) | (esel_flat[2*IDX+1] & rise[IDX]);
      assign pin_out[IDX]             = octl[IDX][OC_LEVEL];
      assign pin_oe[IDX]              = octl[IDX][OC_DIR];
      assign pin_od[IDX]              = octl[IDX][OC_OD];
      assign pin_pull_en[IDX]         = octl[IDX][OC_PEN];
      assign pin_pull_sel[2*IDX +: 2] = octl[IDX][OC_PSEL +: 2];
    end
  end

  gpio_irq_ctrl #(.BANK_PINS(BANK_PINS), .NUM_BANKS(NUM_BANKS)) u_irq (
    .clk(clk), .rst_n(rst_sn), .hit(hit),
    .wr_pend(wr_pend), .wr_mrun(wr_mrun), .wr_mlp(wr_mlp),
    .wdata(bus_wdata[BANK_PINS-1:0]), .low_power(low_power),
    .pending(pend_q), .mask_run(mrun_q), .mask_lp(mlp_q), .irq(irq)
  );

  always_comb begin
    rdata_d = '0;
    if (bus_rd) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (bus_addr == ADDR_PEND0 + 8'(b)) rdata_d = 8'(pend_q[b*BANK_PINS +: BANK_PINS]);
        if (bus_addr == ADDR_MRUN0 + 8'(b)) rdata_d = 8'(mrun_q[b*BANK_PINS +: BANK_PINS]);
        if (bus_addr == ADDR_MLP0  + 8'(b)) rdata_d = 8'(mlp_q[b*BANK_PINS +: BANK_PINS]);
        for (int p = 0; p < BANK_PINS; p++) begin
          if (bus_addr == octl_addr(b, p)) rdata_d = octl[b*BANK_PINS+p];
          if (bus_addr == ictl_addr(b, p))
            rdata_d = {5'b0, esel_flat[2*(b*BANK_PINS+p) +: 2], lvl[b*BANK_PINS+p]};
        end
      end
    end
  end
  assign bus_rdata = rdata_d;
endmodule

// File: rtl/gpio_edge_bank_chk.sv
module gpio_edge_bank_chk #(
  parameter int NUM_PINS = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_wr,
  input logic                  bus_rd,
  input logic [7:0]            bus_rdata,
  input logic                  low_power,
  input logic                  irq,
  input logic [NUM_PINS-1:0]   pin_oe,
  input logic [NUM_PINS-1:0]   pending,
  input logic [NUM_PINS-1:0]   mask_run,
  input logic [2*NUM_PINS-1:0] esel_flat
);
  logic [NUM_PINS-1:0] sel_any;
  always_comb
    for (int i = 0; i < NUM_PINS; i++) sel_any[i] = |esel_flat[2*i +: 2];

  AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == 8'h00); // R8
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> (pending & $past(pending)) == $past(pending)); // R9
  AST_PEND_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pending & ~$past(pending) & ~$past(sel_any)) == '0); // R4
  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    pending == '0 |-> !irq); // R7
  AST_IRQ_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!low_power && (&mask_run)) |-> !irq); // R6
  AST_OE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> pin_oe == $past(pin_oe)); // R2
endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst_n(rst_sn), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .low_power(low_power), .irq(irq), .pin_oe(pin_oe),
  .pending(pend_q), .mask_run(mrun_q), .esel_flat(esel_flat)
);

// File: tb/sim_gpio_edge_bank.sv
`timescale 1ns/1ps
module sim_gpio_edge_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr, bus_wdata, bus_rdata;
  logic        bus_wr, bus_rd, low_power, irq;
  logic [15:0] pad_in, pin_out, pin_oe, pin_od, pin_pull_en;
  logic [31:0] pin_pull_sel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model
  logic [7:0]  oc_m [16];
  logic [1:0]  es_m [16];
  logic [15:0] pend_m, mrun_m, mlp_m, pad_m;

  always #2 clk = ~clk;

  gpio_edge_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .low_power(low_power), .irq(irq), .pin_out(pin_out), .pin_oe(pin_oe),
    .pin_od(pin_od), .pin_pull_en(pin_pull_en), .pin_pull_sel(pin_pull_sel)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    logic [7:0] r = 8'h00;
    for (int b = 0; b < 2; b++) begin
      if (int'(a) == 'h0B + b) r = pend_m[b*8 +: 8];
      if (int'(a) == 'h19 + b) r = mrun_m[b*8 +: 8];
      if (int'(a) == 'h1B + b) r = mlp_m[b*8 +: 8];
      for (int p = 0; p < 8; p++) begin
        if (int'(a) == 'h2B + b*16 + p) r = oc_m[b*8+p];
        if (int'(a) == 'h33 + b*16 + p) r = {5'b0, es_m[b*8+p], pad_m[b*8+p]};
      end
    end
    return r;
  endfunction

  function automatic void model_wr(input logic [7:0] a, input logic [7:0] d);
    for (int b = 0; b < 2; b++) begin
      if (int'(a) == 'h0B + b) pend_m[b*8 +: 8] = pend_m[b*8 +: 8] & ~d;
      if (int'(a) == 'h19 + b) mrun_m[b*8 +: 8] = d;
      if (int'(a) == 'h1B + b) mlp_m[b*8 +: 8]  = d;
      for (int p = 0; p < 8; p++) begin
        if (int'(a) == 'h2B + b*16 + p) oc_m[b*8+p] = d;
        if (int'(a) == 'h33 + b*16 + p) es_m[b*8+p] = d[2:1];
      end
    end
  endfunction

  function automatic logic exp_irq();
    return |(pend_m & ~(low_power ? mlp_m : mrun_m));
  endfunction

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    model_wr(a, d);
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic read_check(input string req, input logic [7:0] a);
    logic [7:0] d;
    bus_read(a, d);
    check(req, {24'h0, d}, {24'h0, exp_rd(a)});
  endtask

  task automatic set_pads(input logic [15:0] v);
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      if (es_m[i][0] && pad_m[i] && !v[i]) pend_m[i] = 1'b1;
      if (es_m[i][1] && !pad_m[i] && v[i]) pend_m[i] = 1'b1;
    end
    pad_in = v; pad_m = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_pins();
    logic [15:0] eo, eoe, eod, epe;
    logic [31:0] eps;
    for (int i = 0; i < 16; i++) begin
      eo[i] = oc_m[i][0]; eoe[i] = oc_m[i][5]; eod[i] = oc_m[i][4];
      epe[i] = oc_m[i][3]; eps[2*i +: 2] = oc_m[i][2:1];
    end
    #1;
    check("R2 pin_out", {16'h0, pin_out}, {16'h0, eo});
    check("R2 pin_oe", {16'h0, pin_oe}, {16'h0, eoe});
    check("R2 pin_od", {16'h0, pin_od}, {16'h0, eod});
    check("R2 pin_pull_en", {16'h0, pin_pull_en}, {16'h0, epe});
    check("R2 pin_pull_sel", pin_pull_sel, eps);
    check("R7 irq", {31'h0, irq}, {31'h0, exp_irq()});
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'h5EED_0C0D));
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_wr = 0; bus_rd = 0;
    pad_in = '0; low_power = 0;
    for (int i = 0; i < 16; i++) begin oc_m[i] = '0; es_m[i] = '0; end
    pend_m = '0; mrun_m = '1; mlp_m = '1; pad_m = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check_pins();
    check("R1 irq", {31'h0, irq}, 32'h0);
    for (int a = 'h0B; a <= 'h4A; a++) read_check("R1 reset regs", 8'(a));
    bus_read(8'h1C, d);
    check("R1 low-power mask bank1", {24'h0, d}, 32'hFF);

    // R2 output control fields
    bus_write(8'h2B, 8'b0010_1011);
    bus_write(8'h3C, 8'b0001_0111);
    check_pins();
    check("R2 pin0 oe", {31'h0, pin_oe[0]}, 32'h1);
    check("R2 pin9 pull_sel", {30'h0, pin_pull_sel[19:18]}, 32'h3);
    read_check("R2 readback", 8'h3C);

    // R3 input control: select bits, pad level, ignored bits
    bus_write(8'h36, 8'hFF);
    read_check("R3 ictl pad low", 8'h36);
    check("R3 ictl value", {24'h0, exp_rd(8'h36)}, 32'h06);
    @(negedge clk); pad_in[3] = 1'b1;
    @(negedge clk);
    bus_read(8'h36, d);
    check("R3 level after two edges", {31'h0, d[0]}, 32'h1);
    pad_m[3] = 1'b1; pend_m[3] = 1'b1; // both edges selected
    repeat (2) @(negedge clk);
    read_check("R4 both edge rise pend", 8'h0B);

    // R5 write-back clear, zero leaves
    bus_write(8'h0B, 8'h00);
    read_check("R5 zero write keeps", 8'h0B);
    bus_write(8'h0B, 8'h08);
    read_check("R5 one write clears", 8'h0B);

    // R4 rise only / fall only / none
    bus_write(8'h36, 8'h04);            // pin3 rising
    bus_write(8'h43, 8'h02);            // pin8 falling
    bus_write(8'h44, 8'h00);            // pin9 none
    set_pads(16'h0300);                 // pin3 falls, pins 8,9 rise
    read_check("R4 no set on wrong edges", 8'h0B);
    read_check("R4 no set bank1", 8'h0C);
    set_pads(16'h0008);                 // pin3 rises, pins 8,9 fall
    read_check("R4 rise sets pin3", 8'h0B);
    read_check("R4 fall sets pin8 only", 8'h0C);
    check("R4 pend model", {16'h0, pend_m}, 32'h0108);

    // R9 sticky, read does not clear
    repeat (20) @(negedge clk);
    read_check("R9 still pending", 8'h0B);
    read_check("R9 after read", 8'h0C);

    // R6 / R7 masks and low-power select
    check_pins();
    bus_write(8'h19, 8'hF7);
    check_pins();
    check("R7 irq unmasked run", {31'h0, irq}, 32'h1);
    @(negedge clk); low_power = 1'b1;
    check_pins();
    check("R6 lp masks selected", {31'h0, irq}, 32'h0);
    bus_write(8'h1C, 8'hFE);
    check_pins();
    check("R6 lp mask bank1 open", {31'h0, irq}, 32'h1);
    @(negedge clk); low_power = 1'b0;
    check_pins();

    // R5 set wins over same-cycle clear (pin0, both edges)
    bus_write(8'h33, 8'h06);
    @(negedge clk); pad_in[0] = 1'b1; pad_m[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_addr = 8'h0B; bus_wdata = 8'h01; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    pend_m[0] = 1'b1;
    bus_read(8'h0B, d);
    check("R5 set wins over clear", {31'h0, d[0]}, 32'h1);

    // R8 unmapped
    read_check("R8 unmapped 0x00", 8'h00);
    read_check("R8 unmapped 0x4B", 8'h4B);
    read_check("R8 unmapped 0xFF", 8'hFF);
    bus_write(8'h20, 8'hA5);
    bus_write(8'h4B, 8'h5A);
    for (int a = 'h0B; a <= 'h4A; a++) read_check("R8 no side effect", 8'(a));
    #1 check("R8 idle rdata", {24'h0, bus_rdata}, 32'h0);

    // random mix
    for (int n = 0; n < 500; n++) begin
      int op = $urandom % 8;
      int pin = $urandom % 16;
      logic [7:0] a;
      case (op)
        0: bus_write(8'('h2B + (pin/8)*16 + pin%8), 8'($urandom));
        1: bus_write(8'('h33 + (pin/8)*16 + pin%8), 8'($urandom));
        2: bus_write(8'('h0B + ($urandom % 2)), 8'($urandom));
        3: bus_write(8'('h19 + ($urandom % 4)), 8'($urandom & $urandom));
        4: bus_write(8'($urandom % 96), 8'($urandom));
        5: begin
             a = 8'($urandom % 80);
             read_check("R8 random read", a);
           end
        6: set_pads(pad_m ^ 16'($urandom & $urandom));
        default: begin @(negedge clk); low_power = ~low_power; end
      endcase
      check_pins();
    end
    for (int a = 'h0B; a <= 'h4A; a++) read_check("R5 final regs", 8'(a));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule